// File: doc/BRIEF.md
# Interrupt Pending, Enable and Delegation Arbiter

This block holds the machine-level interrupt pending, enable and delegation state of a hart and exposes restricted supervisor views of that state. Each cycle it decides combinationally whether an interrupt should be taken, and it reports which one. Software reaches the state through a small register access port with a selector. A memory-mapped store raises or drops the machine software interrupt. Two wires, a machine timer line and a supervisor external line, feed pending bits directly.

The decision weighs the current privilege level against two global enable bits. Interrupts that are not delegated belong to machine level. Interrupts that are delegated belong to supervisor level. Code that runs at a lower privilege than the owning level can always be interrupted, while code at the owning level can be interrupted only when that level's global enable bit is set. When several interrupts qualify, the lowest-numbered one is taken. Trap entry and vectoring are the consumer's job.

Top module: `irq_deleg_arbiter`

## Requirements
- R1: After reset, all stored pending, enable and delegation bits are zero, `takeIrq` is 0 and `irqCause` is 0.
- R2: An interrupt is a candidate when both its pending bit and its enable bit are set. A non-delegated candidate qualifies when `priv` (U=0, S=1, M=3) is below 3, or when `priv` is 3 and `mGie` is 1.
- R3: A delegated candidate qualifies when `priv` is 0, or when `priv` is 1 and `sGie` is 1. At `priv` 3 a delegated candidate never qualifies.
- R4: If any interrupt qualifies, `takeIrq` is 1 and `irqCause` holds the lowest qualifying bit index with bit XLEN-1 set. Otherwise both outputs are 0.
- R5: Selector 0 (machine pending) reads the full pending vector. A write to it changes only bit 1 (supervisor software) and bit 5 (supervisor timer).
- R6: Selector 2 (delegation) accepts writes only to bits 1, 5, 9 and 12, so writing all ones reads back 0x1222.
- R7: Selector 1 (machine enable) accepts writes only to bits 1, 3, 5, 7, 9 and 12, so writing all ones reads back 0x12AA.
- R8: Selector 3 (supervisor pending) reads pending AND delegation. A write to it changes only bit 1, and only while delegation bit 1 is set.
- R9: Selector 4 (supervisor enable) reads enable AND delegation. A write to it changes only the enable bits whose delegation bit is set.
- R10: A store with `swStoreValid` high and `swStoreOffset` equal to 0 copies bit 0 of `swStoreData` into pending bit 3 (machine software). Stores to any other offset change nothing.
- R11: Pending bit 7 equals `mTimerIrq` and pending bit 9 equals `sExtIrq` in the same cycle. No register write changes either bit.
- R12: `csrRdata` is combinational from the selected state. A write takes effect at the clock edge where `csrWe` is high, so the new value is visible from the next cycle. Selectors 5 to 7 read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| priv | input | 2 | Current privilege level: U=0, S=1, M=3 |
| mGie | input | 1 | Global machine interrupt enable |
| sGie | input | 1 | Global supervisor interrupt enable |
| csrWe | input | 1 | Register write strobe |
| csrSel | input | 3 | Register selector 0..4 |
| csrWdata | input | XLEN | Register write data |
| csrRdata | output | XLEN | Register read data for `csrSel` |
| swStoreValid | input | 1 | Memory-mapped software interrupt store strobe |
| swStoreOffset | input | OFFW | Byte offset of the store |
| swStoreData | input | 8 | First data byte of the store |
| mTimerIrq | input | 1 | Machine timer interrupt line |
| sExtIrq | input | 1 | Supervisor external interrupt line |
| takeIrq | output | 1 | An interrupt should be taken now |
| irqCause | output | XLEN | Interrupt flag in the top bit plus the winning bit index |

## Verification
The hardest situation to reach is a precise mix of delegated and non-delegated pending interrupts under each privilege level and enable setting, because the pending state comes from three different paths: register writes, the store path and the input lines. The bench sweeps every combination of the five drivable pending bits, every subset of the four delegable bits and several enable masks. For each combination it walks all privilege and global-enable settings, so that interrupts owned by both levels compete in every order. Directed sequences cover the supervisor views with delegation toggled between writes, so that a masked write can be seen to leave the machine registers unchanged.

// File: rtl/irq_deleg_pkg.sv
package irq_deleg_pkg;

  typedef enum logic [2:0] {
    SEL_MPEND = 3'd0,
    SEL_MEN   = 3'd1,
    SEL_DELEG = 3'd2,
    SEL_SPEND = 3'd3,
    SEL_SEN   = 3'd4
  } csr_sel_e;

  // Bit positions set the arbitration order, so they are fixed.
  localparam int BIT_SSW  = 1;
  localparam int BIT_MSW  = 3;
  localparam int BIT_STIM = 5;
  localparam int BIT_MTIM = 7;
  localparam int BIT_SEXT = 9;
  localparam int BIT_COP  = 12;

  typedef logic [1:0] priv_t;
  localparam priv_t PRIV_U = 2'd0;
  localparam priv_t PRIV_S = 2'd1;
  localparam priv_t PRIV_M = 2'd3;

  typedef struct packed {
    logic wrMPend;
    logic wrMEn;
    logic wrDeleg;
    logic wrSPend;
    logic wrSEn;
    logic swLoad;
  } wr_strobe_t;

endpackage

// File: rtl/irq_deleg_ctrl.sv
module irq_deleg_ctrl
  import irq_deleg_pkg::*;
#(
  parameter int OFFW = 12
) (
  input  logic            csrWe,
  input  logic [2:0]      csrSel,
  input  logic            swStoreValid,
  input  logic [OFFW-1:0] swStoreOffset,
  output wr_strobe_t      strobe
);

  always_comb begin
    strobe = '0;
    if (csrWe) begin
      unique case (csr_sel_e'(csrSel))
        SEL_MPEND: strobe.wrMPend = 1'b1;
        SEL_MEN:   strobe.wrMEn   = 1'b1;
        SEL_DELEG: strobe.wrDeleg = 1'b1;
        SEL_SPEND: strobe.wrSPend = 1'b1;
        SEL_SEN:   strobe.wrSEn   = 1'b1;
        default:   ;
      endcase
    end
    strobe.swLoad = swStoreValid && (swStoreOffset == '0);
  end

endmodule

// File: rtl/irq_deleg_dp.sv
module irq_deleg_dp
  import irq_deleg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NIRQ = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  wr_strobe_t      strobe,
  input  logic [2:0]      csrSel,
  input  logic [XLEN-1:0] csrWdata,
  input  logic [7:0]      swStoreData,
  input  logic            mTimerIrq,
  input  logic            sExtIrq,
  output logic [NIRQ-1:0] pendVec,
  output logic [NIRQ-1:0] enVec,
  output logic [NIRQ-1:0] delegVec,
  output logic [XLEN-1:0] csrRdata
);

  localparam logic [NIRQ-1:0] ONE = NIRQ'(1);
  localparam logic [NIRQ-1:0] DELEG_MASK =
    (ONE << BIT_SSW) | (ONE << BIT_STIM) | (ONE << BIT_SEXT) | (ONE << BIT_COP);
  localparam logic [NIRQ-1:0] EN_MASK = DELEG_MASK | (ONE << BIT_MSW) | (ONE << BIT_MTIM);

  logic sswPend, stimPend, mswPend;
  logic [NIRQ-1:0] enReg, delegReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sswPend  <= 1'b0;
      stimPend <= 1'b0;
      mswPend  <= 1'b0;
      enReg    <= '0;
      delegReg <= '0;
    end else begin
      if (strobe.wrMPend) begin
        sswPend  <= csrWdata[BIT_SSW];
        stimPend <= csrWdata[BIT_STIM];
      end
      if (strobe.wrSPend && delegReg[BIT_SSW])
        sswPend <= csrWdata[BIT_SSW];
      if (strobe.wrMEn)
        enReg <= NIRQ'(csrWdata & XLEN'(EN_MASK));
      if (strobe.wrSEn)
        enReg <= (enReg & ~delegReg) | (NIRQ'(csrWdata & XLEN'(EN_MASK)) & delegReg);
      if (strobe.wrDeleg)
        delegReg <= NIRQ'(csrWdata & XLEN'(DELEG_MASK));
      if (strobe.swLoad)
        mswPend <= |(swStoreData & 8'h01);
    end
  end

  always_comb begin
    pendVec           = '0;
    pendVec[BIT_SSW]  = sswPend;
    pendVec[BIT_MSW]  = mswPend;
    pendVec[BIT_STIM] = stimPend;
    pendVec[BIT_MTIM] = mTimerIrq;
    pendVec[BIT_SEXT] = sExtIrq;
  end

  assign enVec    = enReg;
  assign delegVec = delegReg;

  logic [NIRQ-1:0] rdVec;
  always_comb begin
    unique case (csr_sel_e'(csrSel))
      SEL_MPEND: rdVec = pendVec;
      SEL_MEN:   rdVec = enReg;
      SEL_DELEG: rdVec = delegReg;
      SEL_SPEND: rdVec = pendVec & delegReg;
      SEL_SEN:   rdVec = enReg & delegReg;
      default:   rdVec = '0;
    endcase
  end
  assign csrRdata = XLEN'(rdVec);

endmodule

// File: rtl/irq_deleg_pick.sv
module irq_deleg_pick
  import irq_deleg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NIRQ = 16
) (
  input  logic [NIRQ-1:0] pendVec,
  input  logic [NIRQ-1:0] enVec,
  input  logic [NIRQ-1:0] delegVec,
  input  logic [1:0]      priv,
  input  logic            mGie,
  input  logic            sGie,
  output logic            takeIrq,
  output logic [XLEN-1:0] irqCause
);

  localparam int IDXW = $clog2(NIRQ);

  logic mOk, sOk;
  assign mOk = (priv < PRIV_M) || mGie;
  assign sOk = (priv < PRIV_S) || ((priv == PRIV_S) && sGie);

  logic [NIRQ-1:0] live, grant;
  assign live = pendVec & enVec &
                ((~delegVec & {NIRQ{mOk}}) | (delegVec & {NIRQ{sOk}}));

  // Ripple from bit 0 upward: a bit wins only if nothing below it is live.
  logic [NIRQ:0] clearBelow;
  assign clearBelow[0] = 1'b1;
  for (genvar i = 0; i < NIRQ; i++) begin : g_prio
    assign grant[i]        = live[i] & clearBelow[i];
    assign clearBelow[i+1] = clearBelow[i] & ~live[i];
  end

  logic [IDXW-1:0] idx;
  always_comb begin
    idx = '0;
    for (int i = 0; i < NIRQ; i++)
      if (grant[i]) idx = idx | IDXW'(i);
  end

  assign takeIrq  = ~clearBelow[NIRQ];
  assign irqCause = takeIrq ? ({1'b1, {(XLEN-1){1'b0}}} | XLEN'(idx)) : '0;

endmodule

// File: rtl/irq_deleg_arbiter.sv
module irq_deleg_arbiter
  import irq_deleg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NIRQ = 16,
  parameter int OFFW = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      priv,
  input  logic            mGie,
  input  logic            sGie,
  input  logic            csrWe,
  input  logic [2:0]      csrSel,
  input  logic [XLEN-1:0] csrWdata,
  output logic [XLEN-1:0] csrRdata,
  input  logic            swStoreValid,
  input  logic [OFFW-1:0] swStoreOffset,
  input  logic [7:0]      swStoreData,
  input  logic            mTimerIrq,
  input  logic            sExtIrq,
  output logic            takeIrq,
  output logic [XLEN-1:0] irqCause
);

  wr_strobe_t      strobe;
  logic [NIRQ-1:0] pendVec, enVec, delegVec;

  irq_deleg_ctrl #(.OFFW(OFFW)) u_ctrl (
    .csrWe(csrWe), .csrSel(csrSel), .swStoreValid(swStoreValid),
    .swStoreOffset(swStoreOffset), .strobe(strobe)
  );

  irq_deleg_dp #(.XLEN(XLEN), .NIRQ(NIRQ)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .csrSel(csrSel),
    .csrWdata(csrWdata), .swStoreData(swStoreData), .mTimerIrq(mTimerIrq),
    .sExtIrq(sExtIrq), .pendVec(pendVec), .enVec(enVec), .delegVec(delegVec),
    .csrRdata(csrRdata)
  );

  irq_deleg_pick #(.XLEN(XLEN), .NIRQ(NIRQ)) u_pick (
    .pendVec(pendVec), .enVec(enVec), .delegVec(delegVec), .priv(priv),
    .mGie(mGie), .sGie(sGie), .takeIrq(takeIrq), .irqCause(irqCause)
  );

endmodule

// File: rtl/irq_deleg_arbiter_chk.sv
module irq_deleg_arbiter_chk #(
  parameter int XLEN = 32,
  parameter int NIRQ = 16,
  parameter int OFFW = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic [1:0]      priv,
  input logic            mGie,
  input logic            sGie,
  input logic            csrWe,
  input logic [2:0]      csrSel,
  input logic [XLEN-1:0] csrWdata,
  input logic            swStoreValid,
  input logic [OFFW-1:0] swStoreOffset,
  input logic [7:0]      swStoreData,
  input logic            mTimerIrq,
  input logic            sExtIrq,
  input logic            takeIrq,
  input logic [XLEN-1:0] irqCause,
  input logic [NIRQ-1:0] pendVec,
  input logic [NIRQ-1:0] enVec,
  input logic [NIRQ-1:0] delegVec
);

  localparam int IDXW = $clog2(NIRQ);
  localparam logic [NIRQ-1:0] DMASK = NIRQ'(16'h1222);

  logic [IDXW-1:0] winIdx;
  assign winIdx = irqCause[IDXW-1:0];

  p_cause_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> irqCause[XLEN-1]);
  p_idle_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    !takeIrq |-> (irqCause == '0));
  p_winner_live_r2: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (pendVec[winIdx] && enVec[winIdx]));
  p_mmode_masked_r2: assert property (@(posedge clk) disable iff (!rstN)
    (priv == 2'd3 && !mGie) |-> !takeIrq);
  p_smode_deleg_r3: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && priv == 2'd1 && delegVec[winIdx]) |-> sGie);
  p_deleg_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    (csrWe && csrSel == 3'd2) |=> (delegVec == $past(NIRQ'(csrWdata & XLEN'(DMASK)))));
  p_sw_store_r10: assert property (@(posedge clk) disable iff (!rstN)
    (swStoreValid && swStoreOffset == '0) |=> (pendVec[3] == $past(|(swStoreData & 8'h01))));
  p_spend_guard_r8: assert property (@(posedge clk) disable iff (!rstN)
    (csrWe && csrSel == 3'd3 && !delegVec[1]) |=> $stable(pendVec[1]));
  p_line_follow_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec[7] == mTimerIrq) && (pendVec[9] == sExtIrq));

endmodule

bind irq_deleg_arbiter irq_deleg_arbiter_chk #(.XLEN(XLEN), .NIRQ(NIRQ), .OFFW(OFFW)) u_chk (
  .clk(clk), .rstN(rstN), .priv(priv), .mGie(mGie), .sGie(sGie),
  .csrWe(csrWe), .csrSel(csrSel), .csrWdata(csrWdata),
  .swStoreValid(swStoreValid), .swStoreOffset(swStoreOffset),
  .swStoreData(swStoreData), .mTimerIrq(mTimerIrq), .sExtIrq(sExtIrq),
  .takeIrq(takeIrq), .irqCause(irqCause), .pendVec(pendVec),
  .enVec(enVec), .delegVec(delegVec)
);

// File: tb/tb_irq_deleg_arbiter.sv
`timescale 1ns/1ps
module tb_irq_deleg_arbiter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  priv = 2'd3;
  logic        mGie = 1'b0, sGie = 1'b0;
  logic        csrWe = 1'b0;
  logic [2:0]  csrSel = 3'd0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata;
  logic        swStoreValid = 1'b0;
  logic [11:0] swStoreOffset = '0;
  logic [7:0]  swStoreData = '0;
  logic        mTimerIrq = 1'b0, sExtIrq = 1'b0;
  logic        takeIrq;
  logic [31:0] irqCause;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_deleg_arbiter dut (
    .clk(clk), .rstN(rstN), .priv(priv), .mGie(mGie), .sGie(sGie),
    .csrWe(csrWe), .csrSel(csrSel), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .swStoreValid(swStoreValid), .swStoreOffset(swStoreOffset),
    .swStoreData(swStoreData), .mTimerIrq(mTimerIrq), .sExtIrq(sExtIrq),
    .takeIrq(takeIrq), .irqCause(irqCause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csrWrite(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    csrWe = 1'b1; csrSel = s; csrWdata = d;
    @(negedge clk);
    csrWe = 1'b0;
  endtask

  task automatic readChk(input logic [2:0] s, input logic [31:0] exp, input string tag);
    csrSel = s;
    #0.5;
    chk(tag, csrRdata, exp);
  endtask

  task automatic swStore(input logic [11:0] off, input logic [7:0] d);
    @(negedge clk);
    swStoreValid = 1'b1; swStoreOffset = off; swStoreData = d;
    @(negedge clk);
    swStoreValid = 1'b0;
  endtask

  function automatic logic [32:0] model(input logic [15:0] pend, input logic [15:0] en,
                                        input logic [15:0] dlg, input logic [1:0] pv,
                                        input logic mg, input logic sg);
    logic mOk, sOk, tk;
    logic [31:0] cs;
    mOk = (pv != 2'd3) || mg;
    sOk = (pv == 2'd0) || (pv == 2'd1 && sg);
    tk = 1'b0; cs = '0;
    for (int i = 0; i < 16; i++)
      if (!tk && pend[i] && en[i] && (dlg[i] ? sOk : mOk)) begin
        tk = 1'b1;
        cs = 32'h8000_0000 | i;
      end
    return {tk, cs};
  endfunction

  function automatic void summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] enSet [4];
    enSet[0] = 16'h12AA; enSet[1] = 16'h0202; enSet[2] = 16'h1088; enSet[3] = 16'h12A8;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int s = 0; s < 5; s++) readChk(3'(s), 32'h0, "R1 reset read");
    chk("R1 takeIrq", {31'b0, takeIrq}, 32'h0);
    chk("R1 cause", irqCause, 32'h0);

    // R5: machine pending write mask
    csrWrite(3'd0, 32'hFFFF_FFFF);
    readChk(3'd0, 32'h0000_0022, "R5 pend write mask");
    csrWrite(3'd0, 32'h0);
    readChk(3'd0, 32'h0, "R5 pend clear");

    // R6 / R7: delegation and enable masks
    csrWrite(3'd2, 32'hFFFF_FFFF);
    readChk(3'd2, 32'h0000_1222, "R6 deleg mask");
    csrWrite(3'd1, 32'hFFFF_FFFF);
    readChk(3'd1, 32'h0000_12AA, "R7 enable mask");

    // R9: supervisor enable view
    readChk(3'd4, 32'h0000_1222, "R9 sen read");
    csrWrite(3'd4, 32'h0);
    readChk(3'd1, 32'h0000_0088, "R9 sen write clears delegated only");
    csrWrite(3'd2, 32'h0000_0020);
    csrWrite(3'd4, 32'hFFFF_FFFF);
    readChk(3'd1, 32'h0000_00A8, "R9 sen write sets delegated only");

    // R8: supervisor pending view
    csrWrite(3'd3, 32'hFFFF_FFFF);
    readChk(3'd0, 32'h0, "R8 spend blocked when bit1 not delegated");
    csrWrite(3'd2, 32'h0000_0002);
    csrWrite(3'd3, 32'h0000_0002);
    readChk(3'd0, 32'h0000_0002, "R8 spend write when delegated");
    readChk(3'd3, 32'h0000_0002, "R8 spend read");
    csrWrite(3'd2, 32'h0);
    readChk(3'd3, 32'h0, "R8 spend read masked");
    csrWrite(3'd0, 32'h0);

    // R10: memory-mapped software interrupt
    swStore(12'd4, 8'h01);
    readChk(3'd0, 32'h0, "R10 other offset ignored");
    swStore(12'd0, 8'h01);
    readChk(3'd0, 32'h0000_0008, "R10 store sets");
    swStore(12'd0, 8'hFE);
    readChk(3'd0, 32'h0, "R10 store clears");

    // R11: line-driven bits
    mTimerIrq = 1'b1;
    readChk(3'd0, 32'h0000_0080, "R11 timer line");
    csrWrite(3'd0, 32'h0);
    readChk(3'd0, 32'h0000_0080, "R11 timer not writable");
    mTimerIrq = 1'b0; sExtIrq = 1'b1;
    readChk(3'd0, 32'h0000_0200, "R11 ext line");
    sExtIrq = 1'b0;

    // R12: write timing and unused selectors
    @(negedge clk);
    csrWe = 1'b1; csrSel = 3'd2; csrWdata = 32'h0000_1000;
    #0.5;
    chk("R12 old value before edge", csrRdata, 32'h0);
    @(negedge clk);
    csrWe = 1'b0;
    readChk(3'd2, 32'h0000_1000, "R12 new value after edge");
    csrWrite(3'd7, 32'hFFFF_FFFF);
    for (int s = 5; s < 8; s++) readChk(3'(s), 32'h0, "R12 unused selector reads 0");
    readChk(3'd2, 32'h0000_1000, "R12 unused write no effect deleg");
    readChk(3'd1, 32'h0000_00A8, "R12 unused write no effect enable");

    // R2/R3/R4: sweep
    for (int e = 0; e < 4; e++) begin
      csrWrite(3'd1, {16'h0, enSet[e]});
      for (int d = 0; d < 16; d++) begin
        logic [15:0] dv;
        dv = '0;
        dv[1] = d[0]; dv[5] = d[1]; dv[9] = d[2]; dv[12] = d[3];
        csrWrite(3'd2, {16'h0, dv});
        for (int p = 0; p < 32; p++) begin
          logic [15:0] pv;
          logic [32:0] ex;
          pv = '0;
          pv[1] = p[0]; pv[3] = p[1]; pv[5] = p[2]; pv[7] = p[3]; pv[9] = p[4];
          csrWrite(3'd0, {16'h0, pv & 16'h0022});
          swStore(12'd0, {7'b0, p[1]});
          mTimerIrq = p[3]; sExtIrq = p[4];
          for (int pi = 0; pi < 3; pi++) begin
            for (int g = 0; g < 4; g++) begin
              priv = (pi == 2) ? 2'd3 : 2'(pi);
              mGie = g[0]; sGie = g[1];
              #0.2;
              ex = model(pv, enSet[e] & 16'h12AA, dv, priv, mGie, sGie);
              chk("R2 R3 R4 take", {31'b0, takeIrq}, {31'b0, ex[32]});
              chk("R4 cause", irqCause, ex[31:0]);
            end
          end
        end
      end
    end

    summary();
    $finish;
  end

endmodule